// File: doc/BRIEF.md
# Clocked Byte-Lane Static RAM Pin Emulator

This block copies, inside a fast synchronous design, the pin behaviour of a 16-bit asynchronous static RAM that has two byte lanes. An external master drives the usual SRAM control pins: an active-low select, an active-high select, an active-low write strobe, an active-low output strobe and one active-low enable per byte lane. It also drives an address and write data. The block samples all of these with its own clock through a two-flop synchronizer. It decodes standby, read, write and output-disable from the sampled pins, and it keeps the stored words in an internal array.

A write window is open while the part is selected and the write strobe is low. The window opens on whichever of the three qualifying conditions arrives last. It closes on the first sampled clock on which any of them has dropped. At that close the block stores the address, data and lane enables from the last clock inside the window, one byte lane at a time. Reads are decoded from the synchronized pins and come straight from the array. Each lane has its own output-enable for an external tristate buffer.

Top module: `asram_emu`

## Requirements
- R1: After reset, with all pins idle, no lane is driven: `dq_oe` is 2'b00.
- R2: When `cs_n` is high or `cs` is low, the part is in standby. `dq_oe` is 2'b00, and pulsing `we_n` low changes no stored word.
- R3: A word read (`cs_n`=0, `cs`=1, `we_n`=1, `oe_n`=0, `be_n`=2'b00) drives the stored word at `addr` on `dq_out` with `dq_oe`=2'b11.
- R4: In a read, lane 1 is `dq_out[15:8]`, `dq_oe[1]` and `be_n[1]`, and lane 0 is `dq_out[7:0]`, `dq_oe[0]` and `be_n[0]`. A lane whose enable is high has its `dq_oe` bit at 0 and drives zero data. If both enables are high, nothing is driven.
- R5: With the part selected and both `we_n` and `oe_n` high, `dq_oe` is 2'b00.
- R6: A write window opens only when the last of three conditions becomes true: `cs_n` low, `cs` high and `we_n` low. The order in which they are applied does not matter. The value committed is the `dq_in` value present on the last clock inside the window.
- R7: A write window closes at the first of three events: `cs_n` rises, `we_n` rises or `cs` falls. Each of these three events commits the write.
- R8: At a commit, a lane is written only if its `be_n` bit was low inside the window. The other lane keeps its old byte.
- R9: A low `we_n` on a selected part turns both lanes off, even with `oe_n` low. A read that is already driving stops driving two clocks after `we_n` falls.
- R10: If the address changes inside a single window, only the address held on the last clock of the window is written. A second write needs a new window.
- R11: A change on `addr` shows on `dq_out` exactly two clock edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select |
| cs | input | 1 | Active-high select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| be_n | input | 2 | Active-low byte-lane enables (bit 1 upper, bit 0 lower) |
| addr | input | AW (8) | Word address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data toward the bus |
| dq_oe | output | 2 | Per-lane drive enable for the tristate buffer |

## Verification
Every pin passes through two flops, so read data and the lane enables reflect a pin change two edges later. A commit from a closed window lands in the array on the third edge after the closing pin change. The bench drives pins on falling edges and samples on falling edges. It waits three edges before it samples a read, four edges after a window closes before it reads back, and three edges between a data change inside a window and the close. The two-edge read path is measured edge by edge: the old word must still be present after one edge and the new word after two.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef struct packed {
    logic cs_n;
    logic cs;
    logic we_n;
    logic oe_n;
  } asram_ctrl_t;

  localparam asram_ctrl_t CTRL_IDLE = '{cs_n: 1'b1, cs: 1'b0, we_n: 1'b1, oe_n: 1'b1};

  function automatic logic is_selected(asram_ctrl_t c);
    return !c.cs_n && c.cs;
  endfunction
endpackage

// File: rtl/asram_sync.sv
module asram_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/asram_wctl.sv
module asram_wctl
  import asram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 2,
  localparam int DW   = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  asram_ctrl_t      s_ctrl,
  input  logic [LANES-1:0] s_be_n,
  input  logic [AW-1:0]    s_addr,
  input  logic [DW-1:0]    s_din,
  output logic             commit,
  output logic [AW-1:0]    c_addr,
  output logic [DW-1:0]    c_data,
  output logic [LANES-1:0] c_lanes
);
  logic win, win_q;

  assign win    = is_selected(s_ctrl) && !s_ctrl.we_n;
  assign commit = win_q && !win;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= 1'b0;
      c_addr  <= '0;
      c_data  <= '0;
      c_lanes <= '0;
    end else begin
      win_q <= win;
      if (win) begin
        c_addr  <= s_addr;
        c_data  <= s_din;
        c_lanes <= ~s_be_n;
      end
    end
  end

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst) commit |=> !commit); // R7
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst) (!win && !commit) |=> $stable(c_addr)); // R10
endmodule

// File: rtl/asram_store.sv
module asram_store #(
  parameter int AW    = 8,
  parameter int LANES = 2,
  localparam int DW    = 8 * LANES,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [LANES-1:0] wr_lanes,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lanes[g])
        mem[wr_addr] <= wr_data[g*8 +: 8];
    end

    assign rd_data[g*8 +: 8] = mem[rd_addr];
  end
endmodule

// File: rtl/asram_emu.sv
module asram_emu
  import asram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 2,
  localparam int DW   = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             cs,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] be_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic [LANES-1:0] dq_oe
);
  asram_ctrl_t      raw_ctrl, s_ctrl;
  logic [LANES-1:0] s_be_n;
  logic [AW-1:0]    s_addr;
  logic [DW-1:0]    s_din;
  logic             commit;
  logic [AW-1:0]    c_addr;
  logic [DW-1:0]    c_data;
  logic [LANES-1:0] c_lanes;
  logic [DW-1:0]    rd_word;
  logic             rd_active;

  assign raw_ctrl = '{cs_n: cs_n, cs: cs, we_n: we_n, oe_n: oe_n};

  asram_sync #(.W(4), .RST_VAL(4'(CTRL_IDLE))) i_sync_ctrl (
    .clk(clk), .rst(rst), .d(raw_ctrl), .q(s_ctrl)
  );

  asram_sync #(.W(LANES), .RST_VAL({LANES{1'b1}})) i_sync_be (
    .clk(clk), .rst(rst), .d(be_n), .q(s_be_n)
  );

  asram_sync #(.W(AW + DW)) i_sync_bus (
    .clk(clk), .rst(rst), .d({addr, dq_in}), .q({s_addr, s_din})
  );

  asram_wctl #(.AW(AW), .LANES(LANES)) i_wctl (
    .clk(clk), .rst(rst), .s_ctrl(s_ctrl), .s_be_n(s_be_n),
    .s_addr(s_addr), .s_din(s_din), .commit(commit),
    .c_addr(c_addr), .c_data(c_data), .c_lanes(c_lanes)
  );

  asram_store #(.AW(AW), .LANES(LANES)) i_store (
    .clk(clk), .wr_en(commit), .wr_addr(c_addr), .wr_data(c_data),
    .wr_lanes(c_lanes), .rd_addr(s_addr), .rd_data(rd_word)
  );

  assign rd_active = is_selected(s_ctrl) && s_ctrl.we_n && !s_ctrl.oe_n;

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign dq_oe[g]           = rd_active && !s_be_n[g];
    assign dq_out[g*8 +: 8]   = dq_oe[g] ? rd_word[g*8 +: 8] : 8'h00;

    AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (rst) !dq_oe[g] |-> dq_out[g*8 +: 8] == 8'h00); // R4
  end

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst) !is_selected(s_ctrl) |-> dq_oe == '0); // R2
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst) !s_ctrl.we_n |-> dq_oe == '0); // R9
  AST_COMMIT_NO_DRIVE_OVERLAP: assert property (@(posedge clk) disable iff (rst) commit |-> $past(dq_oe) == '0); // R9
endmodule

// File: tb/test_asram_emu.sv
module test_asram_emu;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n, cs, we_n, oe_n;
  logic [1:0]  be_n;
  logic [AW-1:0] addr;
  logic [15:0] dq_in;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;

  logic [15:0] model [DEPTH];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  asram_emu #(.AW(AW), .LANES(2)) i_asram_emu (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cs(cs), .we_n(we_n), .oe_n(oe_n),
    .be_n(be_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cs_n = 1'b1; cs = 1'b0; we_n = 1'b1; oe_n = 1'b1; be_n = 2'b11;
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] bn);
    logic [15:0] r;
    r = old;
    if (!bn[0]) r[7:0]  = d[7:0];
    if (!bn[1]) r[15:8] = d[15:8];
    return r;
  endfunction

  function automatic logic [1:0] exp_oe(input logic [1:0] bn);
    return ~bn;
  endfunction

  function automatic logic [15:0] exp_data(input logic [15:0] w, input logic [1:0] bn);
    return {bn[1] ? 8'h00 : w[15:8], bn[0] ? 8'h00 : w[7:0]};
  endfunction

  function automatic int perm_item(input int order, input int step);
    int p [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
    return p[order][step];
  endfunction

  task automatic raise_cond(input int i);
    case (i)
      0: cs_n = 1'b0;
      1: cs   = 1'b1;
      default: we_n = 1'b0;
    endcase
  endtask

  // close modes: 0 cs_n rises, 1 we_n rises, 2 cs falls
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] bn,
                    input int order, input int close_mode);
    idle();
    addr = a; be_n = bn; dq_in = 16'($urandom); oe_n = 1'($urandom);
    for (int s = 0; s < 3; s++) begin
      raise_cond(perm_item(order, s));
      clks(2);
    end
    dq_in = d;
    clks(3);
    case (close_mode)
      0: cs_n = 1'b1;
      1: we_n = 1'b1;
      default: cs = 1'b0;
    endcase
    dq_in = ~d;
    clks(4);
    idle();
    clks(1);
    model[a] = merge(model[a], d, bn);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] bn, input string req);
    idle();
    cs_n = 1'b0; cs = 1'b1; oe_n = 1'b0; addr = a; be_n = bn;
    clks(3);
    chk(dq_oe == exp_oe(bn), req, {14'd0, dq_oe}, {14'd0, exp_oe(bn)});
    chk(dq_out == exp_data(model[a], bn), req, dq_out, exp_data(model[a], bn));
    idle();
    clks(1);
  endtask

  initial begin
    idle();
    addr = '0; dq_in = '0;
    void'($urandom(32'h5eed_1234));
    clks(3);
    rst = 1'b0;
    clks(2);
    chk(dq_oe == 2'b00, "R1", {14'd0, dq_oe}, 16'd0);
    chk(dq_out == 16'h0000, "R1", dq_out, 16'd0);

    // fill every word with random orders and close modes (R6, R7)
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 16'h0000;
      wr(AW'(i), 16'($urandom), 2'b00, int'($urandom % 6), int'($urandom % 3));
    end

    // R3 word reads
    for (int i = 0; i < 4; i++) rd(AW'($urandom), 2'b00, "R3");

    // R4 single-lane and no-lane reads
    rd(8'h10, 2'b01, "R4");
    rd(8'h11, 2'b10, "R4");
    rd(8'h12, 2'b11, "R4");

    // R5 output disable
    idle(); cs_n = 1'b0; cs = 1'b1; be_n = 2'b00; addr = 8'h20;
    clks(3);
    chk(dq_oe == 2'b00, "R5", {14'd0, dq_oe}, 16'd0);

    // R2 standby reads on each deselect path
    idle(); cs_n = 1'b1; cs = 1'b1; oe_n = 1'b0; be_n = 2'b00;
    clks(3);
    chk(dq_oe == 2'b00, "R2", {14'd0, dq_oe}, 16'd0);
    cs_n = 1'b0; cs = 1'b0;
    clks(3);
    chk(dq_oe == 2'b00, "R2", {14'd0, dq_oe}, 16'd0);
    // R2 write strobe pulsed while deselected, each path
    idle(); addr = 8'h30; be_n = 2'b00; dq_in = ~model[8'h30];
    cs_n = 1'b1; cs = 1'b1; we_n = 1'b0; clks(4); we_n = 1'b1; clks(4);
    cs_n = 1'b0; cs = 1'b0; we_n = 1'b0; clks(4); we_n = 1'b1; clks(4);
    rd(8'h30, 2'b00, "R2");

    // R6 every opening order
    for (int o = 0; o < 6; o++) begin
      wr(AW'(8'h40 + o), 16'hA500 + 16'(o), 2'b00, o, 1);
      rd(AW'(8'h40 + o), 2'b00, "R6");
    end

    // R7 every closing event
    for (int c = 0; c < 3; c++) begin
      wr(AW'(8'h50 + c), 16'h5A00 + 16'(c), 2'b00, 0, c);
      rd(AW'(8'h50 + c), 2'b00, "R7");
    end

    // R8 lane masks
    wr(8'h60, 16'h1234, 2'b00, 2, 0);
    wr(8'h60, 16'hABCD, 2'b10, 1, 2);
    chk(model[8'h60] == 16'h12CD, "R8", model[8'h60], 16'h12CD);
    rd(8'h60, 2'b00, "R8");
    wr(8'h60, 16'hEF55, 2'b01, 0, 1);
    rd(8'h60, 2'b00, "R8");

    // R9 write strobe cuts an active read
    idle(); cs_n = 1'b0; cs = 1'b1; oe_n = 1'b0; be_n = 2'b00; addr = 8'h70;
    clks(3);
    chk(dq_oe == 2'b11, "R9", {14'd0, dq_oe}, 16'd3);
    we_n = 1'b0; dq_in = 16'h7777;
    @(posedge clk); @(negedge clk);
    chk(dq_oe == 2'b11, "R9", {14'd0, dq_oe}, 16'd3);
    @(posedge clk); @(negedge clk);
    chk(dq_oe == 2'b00, "R9", {14'd0, dq_oe}, 16'd0);
    clks(2);
    we_n = 1'b1;
    clks(4);
    idle(); clks(1);
    model[8'h70] = 16'h7777;
    rd(8'h70, 2'b00, "R9");

    // R10 address moved inside one window
    idle(); cs_n = 1'b0; cs = 1'b1; be_n = 2'b00; addr = 8'h80; dq_in = 16'hDEAD;
    we_n = 1'b0; clks(3);
    addr = 8'h81; dq_in = 16'hBEEF; clks(3);
    we_n = 1'b1; clks(4);
    idle(); clks(1);
    model[8'h81] = 16'hBEEF;
    rd(8'h80, 2'b00, "R10");
    rd(8'h81, 2'b00, "R10");

    // R11 two-edge read latency
    wr(8'h90, 16'h0F0F, 2'b00, 0, 0);
    wr(8'h91, 16'hF0F0, 2'b00, 0, 0);
    idle(); cs_n = 1'b0; cs = 1'b1; oe_n = 1'b0; be_n = 2'b00; addr = 8'h90;
    clks(3);
    addr = 8'h91;
    @(posedge clk); @(negedge clk);
    chk(dq_out == 16'h0F0F, "R11", dq_out, 16'h0F0F);
    @(posedge clk); @(negedge clk);
    chk(dq_out == 16'hF0F0, "R11", dq_out, 16'hF0F0);
    idle(); clks(1);

    // random mix
    for (int i = 0; i < 80; i++) begin
      if ($urandom % 2)
        wr(AW'($urandom), 16'($urandom), 2'($urandom), int'($urandom % 6), int'($urandom % 3));
      else
        rd(AW'($urandom), 2'($urandom), "R3");
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule